// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and sorts them into two outputs: a normal request line and a fast request line. Software configures each source through a small 32-bit register bus. It can enable or disable a single source by writing that source's number. It can route a source to the fast path with a type bit, and it can give the source a 4-bit normal priority. A global control bit and a 5-bit mask gate the normal path.

Two status words tell the interrupt handler which source to serve. The normal status word holds the winning source number in its upper halfword. The fast status word holds the fast source number as a full word. An all-ones value in either word means nothing is pending. A 64-word table of handler addresses sits in the same address space, so software can store one entry per source and read it back.

Reads are combinational on the current address and state. Writes land at the rising clock edge while `bus_we_i` is high. Both request outputs are registered.

Top module: `vec_intc`

## Requirements
- R1: After reset, all configuration reads return zero: control 0x000, mask 0x004, type words, priority words and enable read-back words. Normal status reads 0xFFFF0000, fast status reads 0xFFFFFFFF, and both request outputs are low.
- R2: The handler table occupies 0x100 to 0x1FC. Entry n sits at byte address 0x100 + 4·n and reads back the full 32-bit word last written to it.
- R3: Writing value v to 0x008 sets the enable of source v[5:0]. Writing v to 0x00C clears it. No other enable changes. Enables read back at 0x048 (bit i is source 32+i) and at 0x04C (bit i is source i).
- R4: The type word at 0x010 covers sources 63..32 (bit i is source 32+i). The type word at 0x014 covers sources 31..0. A 1 routes the source to the fast path and a 0 routes it to the normal path. Both words read back as written.
- R5: The priority word at 0x020 + 4·j (j = 0..7) holds the sources 8·(7−j) to 8·(7−j)+7. Source n uses bits 4·(n&7)+3 down to 4·(n&7). Priority 0 is the lowest.
- R6: The normal status at 0x040 returns the winning source number in bits 31:16 and zero in bits 15:0. Only sources that are pending, enabled and normal-typed take part. With no candidate, or with control bit 0 clear, it returns 0xFFFF0000.
- R7: The normal winner is the candidate with the highest priority. Among equal priorities, the highest source number wins.
- R8: The fast status at 0x044 returns the highest-numbered source that is pending, enabled and fast-typed, as a full word. With no such source it returns 0xFFFFFFFF. The control bit does not affect it.
- R9: irq_o is a register. After an edge at which a normal winner exists and the mask value is greater than the winner's priority, irq_o is high; otherwise it is low. A mask of 0x1F passes all priorities and a mask of 0 blocks them all.
- R10: fiq_o is a register. It is high after an edge at which any enabled fast-typed source is pending, and low otherwise.
- R11: Bus writes to the two status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level request lines, bit n is source n |
| bus_addr_i | input | 9 | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
A configuration write and the request-output update can fall on the same clock edge. When an enable or disable write for a source whose line is already held high lands at edge E, the output register at E still samples the old enable. The bench drives such a write and queues two expectations, one judged right after E and one right after the following edge. It then checks that irq_o keeps its old value at E and changes only at the next edge, for both the enable case and the disable case.

// File: rtl/vec_intc_pkg.sv
`timescale 1ns/1ps
package vec_intc_pkg;
    // Byte address width of the register bus.
    localparam int ADDR_W = 9;

    // Register offsets.
    localparam logic [ADDR_W-1:0] A_CTRL      = 9'h000;
    localparam logic [ADDR_W-1:0] A_MASK      = 9'h004;
    localparam logic [ADDR_W-1:0] A_ENA_NUM   = 9'h008;
    localparam logic [ADDR_W-1:0] A_DIS_NUM   = 9'h00C;
    localparam logic [ADDR_W-1:0] A_TYPE_BASE = 9'h010;
    localparam logic [ADDR_W-1:0] A_PRIO_BASE = 9'h020;
    localparam logic [ADDR_W-1:0] A_NSTAT     = 9'h040;
    localparam logic [ADDR_W-1:0] A_FSTAT     = 9'h044;
    localparam logic [ADDR_W-1:0] A_ENRD_BASE = 9'h048;
    localparam logic [ADDR_W-1:0] A_VEC_BASE  = 9'h100;

    // Control word: vectored normal reporting enable.
    localparam int CTRL_NEN_BIT = 0;
endpackage

// File: rtl/vec_intc_arb.sv
`timescale 1ns/1ps
// Binary tournament tree: highest priority wins, ties go to the higher index.
module vec_intc_arb
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           valid_o,
    output logic [$clog2(NUM_SRC)-1:0]     idx_o
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int NODES = 2 * NUM_SRC - 1;

    // Heap-ordered nodes: node k has children 2k+1 (lower indices) and 2k+2.
    logic              nv [NODES];
    logic [SRC_W-1:0]  ni [NODES];
    logic [PRIO_W-1:0] np [NODES];

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_leaf
            assign nv[NUM_SRC-1+g] = req_i[g];
            assign ni[NUM_SRC-1+g] = SRC_W'(g);
            assign np[NUM_SRC-1+g] = prio_i[g];
        end
        for (g = 0; g < NUM_SRC - 1; g++) begin : g_node
            logic take_hi;
            assign take_hi = nv[2*g+2] && (!nv[2*g+1] || (np[2*g+2] >= np[2*g+1]));
            assign nv[g]   = nv[2*g+1] | nv[2*g+2];
            assign ni[g]   = take_hi ? ni[2*g+2] : ni[2*g+1];
            assign np[g]   = take_hi ? np[2*g+2] : np[2*g+1];
        end
    endgenerate

    assign valid_o = nv[0];
    assign idx_o   = ni[0];
endmodule

// File: rtl/vec_intc_regs.sv
`timescale 1ns/1ps
// Configuration state and handler table, with the configuration read path.
module vec_intc_regs
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    parameter int DATA_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic [DATA_W-1:0]              rd_data_o,
    output logic                           nen_o,
    output logic [MASK_W-1:0]              mask_o,
    output logic [NUM_SRC-1:0]             en_o,
    output logic [NUM_SRC-1:0]             ftype_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o
);
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int PER_PRIO  = DATA_W / PRIO_W;
    localparam int PRIO_REGS = NUM_SRC / PER_PRIO;
    localparam int WORD_REGS = NUM_SRC / DATA_W;
    localparam int VEC_LSB   = SRC_W + 2;

    typedef struct packed {
        logic                           nen;
        logic [MASK_W-1:0]              mask;
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0]             ftype;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NUM_SRC-1:0][DATA_W-1:0] vec_d, vec_q;
    logic in_vec;

    assign in_vec = (addr_i[ADDR_W-1:VEC_LSB] == A_VEC_BASE[ADDR_W-1:VEC_LSB]);

    // Next-state computation.
    always_comb begin
        cfg_d = cfg_q;
        vec_d = vec_q;
        if (wr_en_i) begin
            if (addr_i == A_CTRL)    cfg_d.nen  = wr_data_i[CTRL_NEN_BIT];
            if (addr_i == A_MASK)    cfg_d.mask = wr_data_i[MASK_W-1:0];
            if (addr_i == A_ENA_NUM) cfg_d.en[wr_data_i[SRC_W-1:0]] = 1'b1;
            if (addr_i == A_DIS_NUM) cfg_d.en[wr_data_i[SRC_W-1:0]] = 1'b0;
            for (int t = 0; t < WORD_REGS; t++) begin
                if (addr_i == A_TYPE_BASE + ADDR_W'(4 * t))
                    cfg_d.ftype[DATA_W*(WORD_REGS-1-t) +: DATA_W] = wr_data_i;
            end
            for (int j = 0; j < PRIO_REGS; j++) begin
                if (addr_i == A_PRIO_BASE + ADDR_W'(4 * j)) begin
                    for (int k = 0; k < PER_PRIO; k++)
                        cfg_d.prio[PER_PRIO*(PRIO_REGS-1-j)+k] = wr_data_i[PRIO_W*k +: PRIO_W];
                end
            end
            if (in_vec) vec_d[addr_i[VEC_LSB-1:2]] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Handler table has no reset.
    always_ff @(posedge clk) begin
        vec_q <= vec_d;
    end

    // Configuration read path.
    always_comb begin
        rd_data_o = '0;
        if (addr_i == A_CTRL) rd_data_o[CTRL_NEN_BIT] = cfg_q.nen;
        if (addr_i == A_MASK) rd_data_o[MASK_W-1:0]   = cfg_q.mask;
        for (int t = 0; t < WORD_REGS; t++) begin
            if (addr_i == A_TYPE_BASE + ADDR_W'(4 * t))
                rd_data_o = cfg_q.ftype[DATA_W*(WORD_REGS-1-t) +: DATA_W];
            if (addr_i == A_ENRD_BASE + ADDR_W'(4 * t))
                rd_data_o = cfg_q.en[DATA_W*(WORD_REGS-1-t) +: DATA_W];
        end
        for (int j = 0; j < PRIO_REGS; j++) begin
            if (addr_i == A_PRIO_BASE + ADDR_W'(4 * j)) begin
                for (int k = 0; k < PER_PRIO; k++)
                    rd_data_o[PRIO_W*k +: PRIO_W] = cfg_q.prio[PER_PRIO*(PRIO_REGS-1-j)+k];
            end
        end
        if (in_vec) rd_data_o = vec_q[addr_i[VEC_LSB-1:2]];
    end

    assign nen_o   = cfg_q.nen;
    assign mask_o  = cfg_q.mask;
    assign en_o    = cfg_q.en;
    assign ftype_o = cfg_q.ftype;
    assign prio_o  = cfg_q.prio;
endmodule

// File: rtl/vec_intc.sv
`timescale 1ns/1ps
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_we_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int HALF  = DATA_W / 2;

    typedef struct packed {
        logic irq;
        logic fiq;
    } pins_t;

    logic [DATA_W-1:0]              cfg_rdata;
    logic                           nen_w;
    logic [MASK_W-1:0]              mask_w;
    logic [NUM_SRC-1:0]             en_w;
    logic [NUM_SRC-1:0]             ftype_w;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
    logic [NUM_SRC-1:0]             nreq, freq;
    logic                           nvalid, fvalid;
    logic [SRC_W-1:0]               nidx, fidx;
    logic [PRIO_W-1:0]              nprio;
    logic [DATA_W-1:0]              nstat, fstat;
    pins_t                          pins_d, pins_q;

    vec_intc_regs #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .MASK_W  (MASK_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (bus_we_i),
        .addr_i    (bus_addr_i),
        .wr_data_i (bus_wdata_i),
        .rd_data_o (cfg_rdata),
        .nen_o     (nen_w),
        .mask_o    (mask_w),
        .en_o      (en_w),
        .ftype_o   (ftype_w),
        .prio_o    (prio_w)
    );

    assign nreq = src_i & en_w & ~ftype_w & {NUM_SRC{nen_w}};
    assign freq = src_i & en_w & ftype_w;

    vec_intc_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_narb (
        .req_i   (nreq),
        .prio_i  (prio_w),
        .valid_o (nvalid),
        .idx_o   (nidx)
    );

    // Fast path: flat priorities, so the highest index wins.
    vec_intc_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_farb (
        .req_i   (freq),
        .prio_i  ('0),
        .valid_o (fvalid),
        .idx_o   (fidx)
    );

    assign nprio = prio_w[nidx];
    assign nstat = nvalid ? {HALF'(nidx), {HALF{1'b0}}} : {{HALF{1'b1}}, {HALF{1'b0}}};
    assign fstat = fvalid ? DATA_W'(fidx) : {DATA_W{1'b1}};

    always_comb begin
        if (bus_addr_i == A_NSTAT)      bus_rdata_o = nstat;
        else if (bus_addr_i == A_FSTAT) bus_rdata_o = fstat;
        else                            bus_rdata_o = cfg_rdata;
    end

    always_comb begin
        pins_d     = pins_q;
        pins_d.irq = nvalid && (MASK_W'(nprio) < mask_w);
        pins_d.fiq = fvalid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign irq_o = pins_q.irq;
    assign fiq_o = pins_q.fiq;
endmodule

// File: rtl/vec_intc_chk.sv
`timescale 1ns/1ps
module vec_intc_chk
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               bus_we_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] en_w,
    input logic [NUM_SRC-1:0] ftype_w,
    input logic               nen_w
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int HALF  = DATA_W / 2;

    // R3
    ena_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_ENA_NUM) |=> en_w[$past(bus_wdata_i[SRC_W-1:0])]);

    // R3
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_DIS_NUM) |=> !en_w[$past(bus_wdata_i[SRC_W-1:0])]);

    // R3
    single_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && (bus_addr_i == A_ENA_NUM || bus_addr_i == A_DIS_NUM))
        |=> ($countones(en_w ^ $past(en_w)) <= 1));

    // R6
    nstat_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == A_NSTAT) |-> (bus_rdata_o[HALF-1:0] == '0 &&
        (bus_rdata_o[DATA_W-1:HALF] == {HALF{1'b1}} || bus_rdata_o[DATA_W-1:HALF] < NUM_SRC)));

    // R8
    fstat_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == A_FSTAT) |-> (bus_rdata_o == {DATA_W{1'b1}} || bus_rdata_o < NUM_SRC));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(nen_w && |(src_i & en_w & ~ftype_w)));

    // R10
    fiq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(|(src_i & en_w & ftype_w)));

    // R10
    fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & en_w & ftype_w)) |=> fiq_o);
endmodule

bind vec_intc vec_intc_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .en_w        (en_w),
    .ftype_w     (ftype_w),
    .nen_w       (nen_w)
);

// File: tb/vec_intc_tb_top.sv
`timescale 1ns/1ps
module vec_intc_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [8:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          is_pin;
        logic [31:0] exp;
        logic [8:0]  a;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    vec_intc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    // Monitor: judges queued expectations a quarter period after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_pin ? {30'd0, irq, fiq} : rdata;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    if (it.is_pin)
                        $display("FAIL %s pins{irq,fiq}: actual=%b expected=%b",
                                 it.tag, act[1:0], it.exp[1:0]);
                    else
                        $display("FAIL %s addr=0x%03h: actual=0x%08h expected=0x%08h",
                                 it.tag, it.a, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic exp_rd(input logic [8:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        sb_q.push_back('{1'b0, e, a, tag});
    endtask

    task automatic exp_pins(input bit e_irq, input bit e_fiq, input string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, {30'd0, e_irq, e_fiq}, addr, tag});
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src = v;
    endtask

    // Write and watch the request pins at the landing edge and the next one.
    task automatic wr_watch(input logic [8:0] a, input logic [31:0] d,
                            input bit irq_now, input bit irq_next, input string tag);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        sb_q.push_back('{1'b1, {30'd0, irq_now, 1'b0}, a, tag});
        @(negedge clk);
        we = 1'b0;
        sb_q.push_back('{1'b1, {30'd0, irq_next, 1'b0}, a, tag});
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_rd(9'h000, 32'h0, "R1 ctrl");
        exp_rd(9'h004, 32'h0, "R1 mask");
        exp_rd(9'h048, 32'h0, "R1 enable hi");
        exp_rd(9'h04C, 32'h0, "R1 enable lo");
        exp_rd(9'h010, 32'h0, "R1 type hi");
        exp_rd(9'h014, 32'h0, "R1 type lo");
        exp_rd(9'h020, 32'h0, "R1 prio word0");
        exp_rd(9'h03C, 32'h0, "R1 prio word7");
        exp_rd(9'h040, 32'hFFFF_0000, "R1 normal status");
        exp_rd(9'h044, 32'hFFFF_FFFF, "R1 fast status");
        exp_pins(1'b0, 1'b0, "R1 pins");

        // R2 handler table
        wr(9'h100, 32'hDEAD_BEEF);
        wr(9'h1FC, 32'h0BAD_F00D);
        wr(9'h144, 32'h1234_5678);
        exp_rd(9'h100, 32'hDEAD_BEEF, "R2 entry0");
        exp_rd(9'h1FC, 32'h0BAD_F00D, "R2 entry63");
        exp_rd(9'h144, 32'h1234_5678, "R2 entry17");

        // R3 enable / disable by number
        wr(9'h008, 32'd5);
        wr(9'h008, 32'd40);
        exp_rd(9'h04C, 32'h0000_0020, "R3 enable lo");
        exp_rd(9'h048, 32'h0000_0100, "R3 enable hi");
        wr(9'h00C, 32'd5);
        exp_rd(9'h04C, 32'h0, "R3 disable lo");
        exp_rd(9'h048, 32'h0000_0100, "R3 other enable kept");

        // R6 control gate, R9 mask extremes
        set_src(64'h1 << 40);
        exp_rd(9'h040, 32'hFFFF_0000, "R6 gated by control");
        exp_pins(1'b0, 1'b0, "R9 gated");
        wr(9'h000, 32'h1);
        exp_rd(9'h040, 32'h0028_0000, "R6 source 40");
        exp_pins(1'b0, 1'b0, "R9 mask zero blocks");
        wr(9'h004, 32'h1F);
        exp_pins(1'b1, 1'b0, "R9 mask 0x1F passes");

        // R7 / R5 priority and tie break
        wr(9'h008, 32'd1);
        wr(9'h008, 32'd3);
        set_src((64'h1 << 40) | 64'h0A);
        exp_rd(9'h040, 32'h0028_0000, "R7 equal prio highest number");
        wr(9'h03C, 32'h0000_00A0);
        exp_rd(9'h03C, 32'h0000_00A0, "R5 prio readback");
        exp_rd(9'h040, 32'h0001_0000, "R7 source1 prio 10");
        wr(9'h03C, 32'h0000_A0A0);
        exp_rd(9'h040, 32'h0003_0000, "R7 tie goes to 3");
        wr(9'h028, 32'h0000_000B);
        exp_rd(9'h040, 32'h0028_0000, "R5 source 40 in word 2");

        // R9 threshold around priority 11
        wr(9'h004, 32'd11);
        exp_pins(1'b0, 1'b0, "R9 mask equals prio");
        wr(9'h004, 32'd12);
        exp_pins(1'b1, 1'b0, "R9 mask above prio");

        // R4 / R8 / R10 fast routing
        wr(9'h010, 32'h0000_0100);
        exp_rd(9'h044, 32'h0000_0028, "R8 fast source 40");
        exp_rd(9'h040, 32'h0003_0000, "R4 source 40 left normal path");
        exp_pins(1'b1, 1'b1, "R10 fast pin");
        wr(9'h008, 32'd50);
        wr(9'h010, 32'h0004_0100);
        set_src((64'h1 << 50) | (64'h1 << 40) | 64'h0A);
        exp_rd(9'h010, 32'h0004_0100, "R4 type readback");
        exp_rd(9'h044, 32'h0000_0032, "R8 highest fast source");

        // R8 independent of control bit
        wr(9'h000, 32'h0);
        exp_rd(9'h040, 32'hFFFF_0000, "R6 control cleared");
        exp_rd(9'h044, 32'h0000_0032, "R8 ignores control");
        exp_pins(1'b0, 1'b1, "R9 irq drops with control");

        // R11 status writes ignored
        wr(9'h044, 32'h0);
        wr(9'h040, 32'h0);
        exp_rd(9'h044, 32'h0000_0032, "R11 fast status unchanged");
        exp_rd(9'h000, 32'h0, "R11 control unchanged");
        exp_rd(9'h048, 32'h0004_0100, "R11 enables unchanged");

        // R10 fast pin falls
        set_src('0);
        exp_pins(1'b0, 1'b0, "R10 no fast source");
        exp_rd(9'h044, 32'hFFFF_FFFF, "R8 none pending");

        // R3 / R9 write landing on the pin-register edge
        wr(9'h000, 32'h1);
        wr(9'h004, 32'h1F);
        set_src(64'h80);
        exp_pins(1'b0, 1'b0, "R9 source 7 not enabled");
        wr_watch(9'h008, 32'd7, 1'b0, 1'b1, "R3 enable edge");
        wr_watch(9'h00C, 32'd7, 1'b1, 1'b0, "R3 disable edge");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule